// File: doc/BRIEF.md
# Chained two-stage free-running time base

This block builds a wide free-running tick counter out of two narrow up-counting channels. The low channel advances on each qualified prescaled tick. It drives a square wave that goes high when its count reaches a set compare value and low when it reaches a clear compare value. A source selector can route that wave to the high channel, which then advances on each rising edge of the wave. With the set value at zero and the clear value at half range, the high channel steps exactly once for every wrap of the low channel. The concatenation of the two counts then forms one continuous count of ticks that is twice as wide.

Each channel stays idle until it receives its own start command. A single block-wide sync command returns both channels and the wave to zero in the same cycle. The high word follows a low-word wrap one clock later, because its edge detect is synchronous. A reader that needs a consistent wide value samples the high word, then the low word, then the high word again, and keeps the result only when the two high samples agree.

Top module: `cascade_timebase`

## Requirements
- R1: After reset, the low count, the high count, the combined count and the wave are all zero, and neither channel runs until it receives its start command.
- R2: Once started by a one-cycle pulse on `lo_start`, the low count rises by exactly one in the cycle after each cycle with `tick` high. Ticks before that start command have no effect.
- R3: The low count wraps from all ones to zero.
- R4: The wave goes high when the low count advances onto `CMP_SET` and goes low when it advances onto `CMP_CLR`; clear takes priority if the two values are equal. Sync forces the wave low.
- R5: With `hi_src` equal to 2'b01, the started high channel rises by one exactly one cycle after each rising edge of the wave. Any other `hi_src` value (2'b00, 2'b10, 2'b11) holds the high count.
- R6: The high count does not move before a one-cycle pulse on `hi_start`, even while wave edges are arriving.
- R7: A cycle with `sync` high sets both counts and the wave to zero in the next cycle, overrides a tick in the same cycle, and leaves both channels started.
- R8: `count` equals the high count in the upper half and the low count in the lower half. A reader that samples the high word twice around the low word, and keeps only a matching pair, obtains the tick count since the last sync.
- R9: The high count wraps from all ones to zero, so the combined count wraps at two to the power of twice the channel width.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Prescaled count qualifier for the low channel |
| lo_start | input | 1 | One-cycle start command for the low channel |
| hi_start | input | 1 | One-cycle start command for the high channel |
| sync | input | 1 | Block-wide counter reset command |
| hi_src | input | 2 | High-channel clock source: 2'b01 selects the low wave, other codes select no source |
| lo_count | output | CNT_W | Low channel count |
| hi_count | output | CNT_W | High channel count |
| lo_wave | output | 1 | Compare-driven square wave of the low channel |
| count | output | 2*CNT_W | Combined count {hi_count, lo_count} |

## Verification
The bench builds the block with CNT_W = 4, CMP_SET = 0 and CMP_CLR = 8. The low channel therefore wraps every 16 ticks, and the combined 8-bit count wraps after 256 ticks. These values bring low-word wraps, high-word wraps and a full wrap of the combined count within a few hundred cycles. The same short cycle also makes the one-cycle lag of the high word after each low wrap occur often. That lag is what the double-sampled read must hide, and it is exercised with continuous ticks, gapped ticks and a sync command that arrives during counting.

// File: rtl/timebase_pkg.sv
package timebase_pkg;
  typedef enum logic [1:0] {
    HI_SRC_NONE  = 2'b00,
    HI_SRC_LWAVE = 2'b01,
    HI_SRC_RSV2  = 2'b10,
    HI_SRC_RSV3  = 2'b11
  } hi_src_e;
endpackage

// File: rtl/tb_rst_sync.sv
module tb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_out
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sh_q[STAGES-1];
endmodule

// File: rtl/tb_lo_chan.sv
module tb_lo_chan #(
  parameter int CNT_W   = 16,
  parameter int CMP_SET = 0,
  parameter int CMP_CLR = 1 << (CNT_W - 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             tick,
  input  logic             start,
  output logic [CNT_W-1:0] cnt,
  output logic             wave
);
  localparam logic [CNT_W-1:0] SET_V = CNT_W'(CMP_SET);
  localparam logic [CNT_W-1:0] CLR_V = CNT_W'(CMP_CLR);

  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             wave_q, wave_d;
  logic             adv;

  assign adv = run_q & tick & ~sync;

  always_comb begin
    run_d  = run_q | start;
    cnt_d  = cnt_q;
    wave_d = wave_q;
    if (sync) begin
      cnt_d  = '0;
      wave_d = 1'b0;
    end else if (adv) begin
      cnt_d = cnt_q + 1'b1;
      if (cnt_d == CLR_V)      wave_d = 1'b0;
      else if (cnt_d == SET_V) wave_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      wave_q <= 1'b0;
    end else begin
      run_q <= run_d;
      if (sync || adv) begin
        cnt_q  <= cnt_d;
        wave_q <= wave_d;
      end
    end
  end

  assign cnt  = cnt_q;
  assign wave = wave_q;
endmodule

// File: rtl/tb_rise_det.sv
module tb_rise_det (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic src,
  output logic rise
);
  logic prev_q, prev_d;

  always_comb prev_d = clr ? 1'b0 : src;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= prev_d;
  end

  assign rise = src & ~prev_q;
endmodule

// File: rtl/tb_hi_chan.sv
module tb_hi_chan #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sync,
  input  logic             step,
  input  logic             start,
  output logic [CNT_W-1:0] cnt
);
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  assign cnt_en = sync | (run_q & step);

  always_comb begin
    run_d = run_q | start;
    if (sync) cnt_d = '0;
    else      cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      run_q <= run_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/cascade_timebase.sv
module cascade_timebase
  import timebase_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CMP_SET = 0,
  parameter int CMP_CLR = 1 << (CNT_W - 1),
  parameter int RST_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               tick,
  input  logic               lo_start,
  input  logic               hi_start,
  input  logic               sync,
  input  logic [1:0]         hi_src,
  output logic [CNT_W-1:0]   lo_count,
  output logic [CNT_W-1:0]   hi_count,
  output logic               lo_wave,
  output logic [2*CNT_W-1:0] count
);
  localparam int TOT_W = 2 * CNT_W;

  logic    rst_n_core;
  logic    hi_clk_src;
  logic    hi_step;
  hi_src_e src_sel;

  tb_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_out (rst_n_core)
  );

  tb_lo_chan #(.CNT_W(CNT_W), .CMP_SET(CMP_SET), .CMP_CLR(CMP_CLR)) u_lo (
    .clk   (clk),
    .rst_n (rst_n_core),
    .sync  (sync),
    .tick  (tick),
    .start (lo_start),
    .cnt   (lo_count),
    .wave  (lo_wave)
  );

  assign src_sel = hi_src_e'(hi_src);

  always_comb begin
    case (src_sel)
      HI_SRC_LWAVE: hi_clk_src = lo_wave;
      default:      hi_clk_src = 1'b0;
    endcase
  end

  tb_rise_det u_edge (
    .clk   (clk),
    .rst_n (rst_n_core),
    .clr   (sync),
    .src   (hi_clk_src),
    .rise  (hi_step)
  );

  tb_hi_chan #(.CNT_W(CNT_W)) u_hi (
    .clk   (clk),
    .rst_n (rst_n_core),
    .sync  (sync),
    .step  (hi_step),
    .start (hi_start),
    .cnt   (hi_count)
  );

  assign count = TOT_W'({hi_count, lo_count});
endmodule

// File: rtl/timebase_chk.sv
module timebase_chk #(
  parameter int CNT_W   = 16,
  parameter int CMP_SET = 0,
  parameter int CMP_CLR = 1 << (CNT_W - 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sync_cmd,
  input logic [1:0]       src_sel,
  input logic [CNT_W-1:0] lo_count,
  input logic [CNT_W-1:0] hi_count,
  input logic             lo_wave
);
  p_sync_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cmd |=> (lo_count == '0 && hi_count == '0 && !lo_wave));

  p_lo_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_cmd |=> ((lo_count == $past(lo_count)) ||
                   (lo_count == CNT_W'($past(lo_count) + 1'b1))));

  p_hi_src_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !sync_cmd |=> ((hi_count == $past(hi_count)) ||
                   ($past(lo_wave) && $past(src_sel) == 2'b01)));

  p_wave_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lo_wave) |-> (lo_count == CNT_W'(CMP_SET)));

  p_wave_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(lo_wave) && !$past(sync_cmd)) |-> (lo_count == CNT_W'(CMP_CLR)));
endmodule

bind cascade_timebase timebase_chk #(
  .CNT_W(CNT_W), .CMP_SET(CMP_SET), .CMP_CLR(CMP_CLR)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_core),
  .sync_cmd (sync),
  .src_sel  (hi_src),
  .lo_count (lo_count),
  .hi_count (hi_count),
  .lo_wave  (lo_wave)
);

// File: tb/tb_cascade_timebase.sv
module tb_cascade_timebase;
  localparam int W   = 4;
  localparam int SET = 0;
  localparam int CLR = 8;
  localparam int MOD = 1 << W;

  logic           clk = 1'b0;
  logic           rst_n;
  logic           tick_i, lo_start_i, hi_start_i, sync_i;
  logic [1:0]     sel_i;
  logic [W-1:0]   lo_count, hi_count;
  logic           lo_wave;
  logic [2*W-1:0] count;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  int m_lo, m_hi, m_ticks;
  bit m_wave, m_prev, m_en_lo, m_en_hi;

  always #4 clk = ~clk;

  cascade_timebase #(.CNT_W(W), .CMP_SET(SET), .CMP_CLR(CLR)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick_i), .lo_start(lo_start_i),
    .hi_start(hi_start_i), .sync(sync_i), .hi_src(sel_i),
    .lo_count(lo_count), .hi_count(hi_count), .lo_wave(lo_wave), .count(count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cmp_all();
    chk("R2 lo_count", int'(lo_count), m_lo);
    chk("R5 hi_count", int'(hi_count), m_hi);
    chk("R4 lo_wave", int'(lo_wave), int'(m_wave));
    chk("R8 count", int'(count), m_hi * MOD + m_lo);
  endtask

  task automatic step(input bit t, input bit s, input bit el, input bit eh);
    bit src, rise;
    tick_i = t; sync_i = s; lo_start_i = el; hi_start_i = eh;
    @(posedge clk);
    src  = (sel_i == 2'b01) ? m_wave : 1'b0;
    rise = src && !m_prev;
    if (s) begin
      m_lo = 0; m_hi = 0; m_wave = 0; m_prev = 0; m_ticks = 0;
    end else begin
      if (m_en_lo && t) begin
        m_lo = (m_lo + 1) % MOD;
        m_ticks = (m_ticks + 1) % (MOD * MOD);
        if (m_lo == CLR)      m_wave = 0;
        else if (m_lo == SET) m_wave = 1;
      end
      if (m_en_hi && rise) m_hi = (m_hi + 1) % MOD;
      m_prev = src;
    end
    m_en_lo = m_en_lo | el;
    m_en_hi = m_en_hi | eh;
    @(negedge clk);
    cmp_all();
  endtask

  task automatic run(input int n, input int gap);
    for (int i = 0; i < n; i++) begin
      step(1'b1, 1'b0, 1'b0, 1'b0);
      for (int g = 0; g < gap; g++) step(1'b0, 1'b0, 1'b0, 1'b0);
    end
  endtask

  task automatic consistent_read(input string tag);
    int h1, l, h2, tries;
    tries = 0;
    do begin
      h1 = int'(hi_count);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      l = int'(lo_count);
      step(1'b0, 1'b0, 1'b0, 1'b0);
      h2 = int'(hi_count);
      tries++;
    end while (h1 != h2 && tries < 4);
    chk(tag, h1 * MOD + l, m_ticks);
  endtask

  initial begin
    rst_n = 1'b0; tick_i = 0; lo_start_i = 0; hi_start_i = 0; sync_i = 0;
    sel_i = 2'b00;
    m_lo = 0; m_hi = 0; m_wave = 0; m_prev = 0; m_en_lo = 0; m_en_hi = 0;
    m_ticks = 0;
    repeat (3) @(negedge clk);
    chk("R1 lo after reset", int'(lo_count), 0);
    chk("R1 hi after reset", int'(hi_count), 0);
    chk("R1 wave after reset", int'(lo_wave), 0);
    rst_n = 1'b1;
    repeat (4) step(1'b0, 1'b0, 1'b0, 1'b0);

    run(5, 0);
    chk("R2 ticks before start ignored", int'(lo_count), 0);
    chk("R1 count idle", int'(count), 0);

    step(1'b0, 1'b0, 1'b1, 1'b0);
    run(3, 0);
    chk("R2 three ticks", int'(lo_count), 3);

    sel_i = 2'b01;
    run(40, 0);
    chk("R6 hi idle before start", int'(hi_count), 0);
    chk("R3 lo wrapped", int'(lo_count), 43 % MOD);

    step(1'b0, 1'b1, 1'b0, 1'b1);
    chk("R7 sync zero lo", int'(lo_count), 0);
    chk("R7 sync zero wave", int'(lo_wave), 0);

    run(16, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R5 one step per wrap", int'(hi_count), 1);
    run(20, 2);
    consistent_read("R8 read after gapped ticks");

    sel_i = 2'b10;
    run(40, 0);
    chk("R5 hold with code 10", int'(hi_count), m_hi);
    sel_i = 2'b00;
    run(20, 0);
    chk("R5 hold with code 00", int'(hi_count), m_hi);

    step(1'b1, 1'b1, 1'b0, 1'b0);
    chk("R7 sync beats tick", int'(count), 0);
    sel_i = 2'b01;
    run(7, 0);
    chk("R7 channels still started", int'(lo_count), 7);

    step(1'b0, 1'b1, 1'b0, 1'b0);
    run(250, 0);
    consistent_read("R8 read near full range");
    run(10, 0);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R9 combined wrapped", int'(count), 260 % (MOD * MOD));
    consistent_read("R9 read after wrap");

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule